// File: doc/BRIEF.md
# Fetch-Stage Branch Prediction Table

This block is a small direct-mapped table that the fetch stage reads every cycle. The table is addressed with the fetch address. Each entry holds a valid bit, an address tag, the target last seen for the branch, and a prediction state. When the fetch address hits an entry whose state predicts taken, the block returns the stored target as the next fetch address. In every other case it returns the sequential address, which is the fetch address plus four.

When a branch resolves later in the pipeline, the resolution port reports four things: the branch address, whether the branch was taken, its real target, and whether the earlier guess was wrong. The block uses these to update the table. A taken branch that missed the table gets a new entry. A wrong guess produces a one-cycle flush request, so the pipeline can discard the younger instructions.

A static input selects the history scheme. In the one-bit scheme the prediction follows the last outcome. In the two-bit scheme the state is a saturating counter, so one stray outcome does not reverse a settled prediction.

Top module: `branch_pred_table`

## Requirements
- R1: After reset no entry is valid, so every lookup misses and `flush_req` stays low.
- R2: A lookup that misses, or that hits an entry predicting not taken, gives `pred_taken`=0 and `pred_next_pc` = `fetch_pc`+4. The sum is taken modulo 2^32, so `fetch_pc`=FFFFFFFC gives 0.
- R3: A resolved taken branch that misses the table claims the entry at its index. The entry gets the branch tag and target and starts in the weak-taken state. The next lookup of that address hits, predicts taken, and returns the target.
- R4: A resolved not-taken branch that misses the table leaves the table unchanged.
- R5: The entry index is `pc[5:2]` and the tag is `pc[31:6]`. An address with the same index but a different tag misses. If that address is then allocated, it replaces the old entry.
- R6: With `mode_two_bit`=1 the state is a saturating counter from 0 to 3. The counter predicts taken at 2 and 3, a taken outcome counts up, and a not-taken outcome counts down. From strong taken (3), two not-taken outcomes in a row are needed before the prediction becomes not taken.
- R7: With `mode_two_bit`=0 each resolution of a hitting entry sets the prediction equal to the outcome.
- R8: A resolved taken branch that hits the table overwrites the stored target with the reported target.
- R9: `flush_req` is high for exactly the one cycle after a cycle where `rsv_valid` and `rsv_mispredict` are both high. It is low at all other times.
- R10: The lookup is combinational. In the cycle that a resolution is presented, a lookup still sees the table as it was before that resolution. The update takes effect at the next rising clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; released synchronously inside the block |
| mode_two_bit | input | 1 | 1 selects the four-state counter, 0 selects the two-state predictor |
| fetch_pc | input | 32 | Current fetch address |
| pred_hit | output | 1 | Fetch address matched a valid entry |
| pred_taken | output | 1 | Prediction is taken |
| pred_next_pc | output | 32 | Next fetch address |
| rsv_valid | input | 1 | A branch resolution is presented |
| rsv_pc | input | 32 | Address of the resolved branch |
| rsv_taken | input | 1 | Actual outcome |
| rsv_target | input | 32 | Actual target address |
| rsv_mispredict | input | 1 | The earlier prediction for this branch was wrong |
| flush_req | output | 1 | Request to discard younger instructions |

## Verification
The hardest situation to reach from the ports is a counter sitting at each of its four levels, which is needed to show the two-bit hysteresis and the saturation at both ends. The stimulus allocates one branch and then resolves it repeatedly with a fixed outcome pattern. Every resolution is followed by a lookup, so each level is reached and observed. Index aliasing is reached by sweeping all sixteen indices and then resolving an address that shares an index but has a different tag. The mispredict flag is always derived from the bench's own prediction, so the flush checks follow real mistakes.

// File: rtl/bpt_pkg.sv
package bpt_pkg;
  // Prediction state: the upper bit is the taken/not-taken guess.
  typedef enum logic [1:0] {
    ST_STRONG_NT = 2'b00,
    ST_WEAK_NT   = 2'b01,
    ST_WEAK_T    = 2'b10,
    ST_STRONG_T  = 2'b11
  } pstate_e;

  function automatic logic guess_taken(pstate_e s);
    return s[1];
  endfunction
endpackage

// File: rtl/bpt_rst_sync.sv
module bpt_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_ni,
  output logic rst_sync_no
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '0;
    else         sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_no = sync_q[STAGES-1];
endmodule

// File: rtl/bpt_state_next.sv
module bpt_state_next
  import bpt_pkg::*;
(
  input  pstate_e cur_i,
  input  logic    taken_i,
  input  logic    two_bit_i,
  output pstate_e nxt_o
);
  always_comb begin
    nxt_o = cur_i;
    if (!two_bit_i) begin
      nxt_o = taken_i ? ST_STRONG_T : ST_STRONG_NT;
    end else if (taken_i) begin
      if (cur_i != ST_STRONG_T) nxt_o = pstate_e'(cur_i + 2'd1);
    end else begin
      if (cur_i != ST_STRONG_NT) nxt_o = pstate_e'(cur_i - 2'd1);
    end
  end
endmodule

// File: rtl/bpt_entry.sv
module bpt_entry
  import bpt_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int TAG_W  = 26
) (
  input  logic              clk,
  input  logic              rst_ni,
  input  logic              alloc_i,
  input  logic              st_wr_i,
  input  logic              tgt_wr_i,
  input  logic [TAG_W-1:0]  tag_i,
  input  logic [ADDR_W-1:0] tgt_i,
  input  pstate_e           st_i,
  output logic              valid_o,
  output logic [TAG_W-1:0]  tag_o,
  output logic [ADDR_W-1:0] tgt_o,
  output pstate_e           st_o
);
  logic              valid_q;
  logic [TAG_W-1:0]  tag_q;
  logic [ADDR_W-1:0] tgt_q;
  pstate_e           st_q;

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni)      valid_q <= 1'b0;
    else if (alloc_i) valid_q <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (alloc_i)  tag_q <= tag_i;
    if (tgt_wr_i) tgt_q <= tgt_i;
    if (st_wr_i)  st_q  <= st_i;
  end

  assign valid_o = valid_q;
  assign tag_o   = tag_q;
  assign tgt_o   = tgt_q;
  assign st_o    = st_q;
endmodule

// File: rtl/branch_pred_table.sv
module branch_pred_table
  import bpt_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int IDX_W  = 4,
  parameter int OFFS_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mode_two_bit,
  input  logic [ADDR_W-1:0] fetch_pc,
  output logic              pred_hit,
  output logic              pred_taken,
  output logic [ADDR_W-1:0] pred_next_pc,
  input  logic              rsv_valid,
  input  logic [ADDR_W-1:0] rsv_pc,
  input  logic              rsv_taken,
  input  logic [ADDR_W-1:0] rsv_target,
  input  logic              rsv_mispredict,
  output logic              flush_req
);
  localparam int ENTRIES = 1 << IDX_W;
  localparam int TAG_W   = ADDR_W - IDX_W - OFFS_W;
  localparam logic [ADDR_W-1:0] STEP = ADDR_W'(1 << OFFS_W);

  logic                rst_sync_n;
  logic [ENTRIES-1:0]  entry_vld;
  logic [TAG_W-1:0]    entry_tag [ENTRIES];
  logic [ADDR_W-1:0]   entry_tgt [ENTRIES];
  pstate_e             entry_st  [ENTRIES];

  bpt_rst_sync #(.STAGES(2)) u_rst_sync (
    .clk         (clk),
    .rst_ni      (rst_n),
    .rst_sync_no (rst_sync_n)
  );

  // Fetch-side lookup
  logic [IDX_W-1:0] f_idx;
  logic [TAG_W-1:0] f_tag;
  assign f_idx = fetch_pc[OFFS_W +: IDX_W];
  assign f_tag = fetch_pc[ADDR_W-1 -: TAG_W];

  always_comb begin
    pred_hit     = entry_vld[f_idx] && (entry_tag[f_idx] == f_tag);
    pred_taken   = pred_hit && guess_taken(entry_st[f_idx]);
    pred_next_pc = pred_taken ? entry_tgt[f_idx] : fetch_pc + STEP;
  end

  // Resolve-side update
  logic [IDX_W-1:0] r_idx;
  logic [TAG_W-1:0] r_tag;
  logic             r_hit;
  pstate_e          r_next;
  assign r_idx = rsv_pc[OFFS_W +: IDX_W];
  assign r_tag = rsv_pc[ADDR_W-1 -: TAG_W];
  assign r_hit = entry_vld[r_idx] && (entry_tag[r_idx] == r_tag);

  bpt_state_next u_state_next (
    .cur_i     (entry_st[r_idx]),
    .taken_i   (rsv_taken),
    .two_bit_i (mode_two_bit),
    .nxt_o     (r_next)
  );

  for (genvar i = 0; i < ENTRIES; i++) begin : g_entry
    localparam logic [IDX_W-1:0] MY_IDX = IDX_W'(i);
    logic    sel, alloc, st_wr, tgt_wr;
    pstate_e st_in;

    always_comb begin
      sel    = rsv_valid && (r_idx == MY_IDX);
      alloc  = sel && !r_hit && rsv_taken;
      st_wr  = alloc || (sel && r_hit);
      tgt_wr = sel && rsv_taken;
      st_in  = alloc ? ST_WEAK_T : r_next;
    end

    bpt_entry #(.ADDR_W(ADDR_W), .TAG_W(TAG_W)) u_entry (
      .clk      (clk),
      .rst_ni   (rst_sync_n),
      .alloc_i  (alloc),
      .st_wr_i  (st_wr),
      .tgt_wr_i (tgt_wr),
      .tag_i    (r_tag),
      .tgt_i    (rsv_target),
      .st_i     (st_in),
      .valid_o  (entry_vld[i]),
      .tag_o    (entry_tag[i]),
      .tgt_o    (entry_tgt[i]),
      .st_o     (entry_st[i])
    );
  end

  // Flush request: one cycle after a reported mispredict
  logic flush_d, flush_q;
  always_comb flush_d = rsv_valid && rsv_mispredict;

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) flush_q <= 1'b0;
    else             flush_q <= flush_d;
  end

  assign flush_req = flush_q;
endmodule

// File: rtl/branch_pred_table_chk.sv
module branch_pred_table_chk #(
  parameter int ADDR_W = 32,
  parameter int IDX_W  = 4,
  parameter int OFFS_W = 2
) (
  input logic                    clk,
  input logic                    rst_ni,
  input logic [ADDR_W-1:0]       fetch_pc,
  input logic                    pred_hit,
  input logic                    pred_taken,
  input logic [ADDR_W-1:0]       pred_next_pc,
  input logic                    rsv_valid,
  input logic [ADDR_W-1:0]       rsv_pc,
  input logic                    rsv_taken,
  input logic                    rsv_mispredict,
  input logic                    flush_req,
  input logic [(1<<IDX_W)-1:0]   vld
);
  localparam logic [ADDR_W-1:0] STEP = ADDR_W'(1 << OFFS_W);

  assert_reset_empty_R1: assert property (@(posedge clk)
    !rst_ni |-> (vld == '0 && !flush_req));

  assert_miss_falls_through_R2: assert property (@(posedge clk) disable iff (!rst_ni)
    !pred_taken |-> (pred_next_pc == fetch_pc + STEP));

  assert_taken_needs_hit_R2: assert property (@(posedge clk) disable iff (!rst_ni)
    pred_taken |-> pred_hit);

  assert_taken_resolve_fills_R3: assert property (@(posedge clk) disable iff (!rst_ni)
    (rsv_valid && rsv_taken) |=> vld[$past(rsv_pc[OFFS_W +: IDX_W])]);

  assert_flush_follows_miss_R9: assert property (@(posedge clk) disable iff (!rst_ni)
    (rsv_valid && rsv_mispredict) |=> flush_req);

  assert_flush_only_on_miss_R9: assert property (@(posedge clk) disable iff (!rst_ni)
    !(rsv_valid && rsv_mispredict) |=> !flush_req);
endmodule

bind branch_pred_table branch_pred_table_chk #(
  .ADDR_W(ADDR_W), .IDX_W(IDX_W), .OFFS_W(OFFS_W)
) u_chk (
  .clk            (clk),
  .rst_ni         (rst_sync_n),
  .fetch_pc       (fetch_pc),
  .pred_hit       (pred_hit),
  .pred_taken     (pred_taken),
  .pred_next_pc   (pred_next_pc),
  .rsv_valid      (rsv_valid),
  .rsv_pc         (rsv_pc),
  .rsv_taken      (rsv_taken),
  .rsv_mispredict (rsv_mispredict),
  .flush_req      (flush_req),
  .vld            (entry_vld)
);

// File: tb/branch_pred_table_test.sv
module branch_pred_table_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        mode_two_bit;
  logic [31:0] fetch_pc;
  logic        pred_hit, pred_taken;
  logic [31:0] pred_next_pc;
  logic        rsv_valid, rsv_taken, rsv_mispredict;
  logic [31:0] rsv_pc, rsv_target;
  logic        flush_req;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  // Bench-side model of the table, built from the requirements
  bit          m_vld [16];
  logic [25:0] m_tag [16];
  logic [31:0] m_tgt [16];
  int          m_st  [16];

  always #2 clk = ~clk;

  branch_pred_table uut (
    .clk(clk), .rst_n(rst_n), .mode_two_bit(mode_two_bit),
    .fetch_pc(fetch_pc), .pred_hit(pred_hit), .pred_taken(pred_taken),
    .pred_next_pc(pred_next_pc), .rsv_valid(rsv_valid), .rsv_pc(rsv_pc),
    .rsv_taken(rsv_taken), .rsv_target(rsv_target),
    .rsv_mispredict(rsv_mispredict), .flush_req(flush_req)
  );

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  function automatic bit m_hit(input logic [31:0] pc);
    return m_vld[pc[5:2]] && (m_tag[pc[5:2]] == pc[31:6]);
  endfunction

  function automatic bit m_taken(input logic [31:0] pc);
    return m_hit(pc) && (m_st[pc[5:2]] >= 2);
  endfunction

  task automatic look(input logic [31:0] pc, input string req);
    logic [31:0] nx;
    fetch_pc = pc;
    #1;
    nx = m_taken(pc) ? m_tgt[pc[5:2]] : pc + 32'd4;
    chk(req, {31'b0, pred_hit},   {31'b0, m_hit(pc)});
    chk(req, {31'b0, pred_taken}, {31'b0, m_taken(pc)});
    chk(req, pred_next_pc, nx);
  endtask

  task automatic resolve(input logic [31:0] pc, input bit tk, input logic [31:0] tgt);
    bit misp;
    int ix;
    ix = pc[5:2];
    @(negedge clk);
    misp = (m_taken(pc) != tk) || (tk && m_taken(pc) && m_tgt[ix] != tgt);
    rsv_valid = 1'b1; rsv_pc = pc; rsv_taken = tk;
    rsv_target = tgt; rsv_mispredict = misp;
    look(pc, "R10 same-cycle lookup sees old state");
    @(posedge clk);
    @(negedge clk);
    rsv_valid = 1'b0; rsv_mispredict = 1'b0;
    if (m_hit(pc)) begin
      if (mode_two_bit) m_st[ix] = tk ? ((m_st[ix] < 3) ? m_st[ix] + 1 : 3)
                                      : ((m_st[ix] > 0) ? m_st[ix] - 1 : 0);
      else              m_st[ix] = tk ? 3 : 0;
      if (tk) m_tgt[ix] = tgt;
    end else if (tk) begin
      m_vld[ix] = 1; m_tag[ix] = pc[31:6]; m_tgt[ix] = tgt; m_st[ix] = 2;
    end
    #1;
    chk("R9 flush after resolve", {31'b0, flush_req}, {31'b0, misp});
    @(negedge clk); #1;
    chk("R9 flush lasts one cycle", {31'b0, flush_req}, 32'd0);
  endtask

  initial begin
    #(4 * 100000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: got hung expected finish");
      $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    logic [31:0] base;
    for (int i = 0; i < 16; i++) m_vld[i] = 0;
    rst_n = 1'b1; mode_two_bit = 1'b1; fetch_pc = '0;
    rsv_valid = 0; rsv_pc = '0; rsv_taken = 0; rsv_target = '0; rsv_mispredict = 0;
    #1 rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1: every index misses after reset
    for (int i = 0; i < 16; i++) look(32'h1000_0000 + i * 4, "R1 reset empty");
    #1 chk("R1 no flush after reset", {31'b0, flush_req}, 32'd0);

    // R2: sequential increment wraps
    look(32'hFFFF_FFFC, "R2 wrap");
    chk("R2 wrap value", pred_next_pc, 32'h0);

    // R4: not-taken miss does not allocate
    resolve(32'h0000_2008, 1'b0, 32'h0000_9000);
    look(32'h0000_2008, "R4 no allocation");

    // R3: allocate every index with a taken branch
    for (int i = 0; i < 16; i++) begin
      base = 32'h0040_0000 + i * 4;
      resolve(base, 1'b1, 32'h0080_0000 + i * 64);
      look(base, "R3 allocated taken");
    end

    // R5: alias at index 3 misses, then replaces
    look(32'h0050_000C, "R5 alias miss");
    resolve(32'h0050_000C, 1'b1, 32'h0000_1234);
    look(32'h0050_000C, "R5 alias allocated");
    look(32'h0040_000C, "R5 old entry evicted");

    // R6: two-bit counter walk on index 5
    mode_two_bit = 1'b1;
    base = 32'h0040_0014;
    for (int s = 0; s < 12; s++) begin
      bit tk;
      tk = (s < 2) || (s == 3) || (s >= 9);
      resolve(base, tk, 32'h0080_0140);
      look(base, "R6 two-bit counter");
    end

    // R7: one-bit mode follows each outcome on index 7
    mode_two_bit = 1'b0;
    base = 32'h0040_001C;
    for (int s = 0; s < 6; s++) begin
      resolve(base, s[0], 32'h0080_01C0);
      look(base, "R7 one-bit follows outcome");
    end

    // R8: taken hit updates target
    mode_two_bit = 1'b1;
    resolve(32'h0040_0020, 1'b1, 32'h00AB_CD00);
    look(32'h0040_0020, "R8 new target");
    chk("R8 target value", pred_next_pc, 32'h00AB_CD00);

    done = 1;
    $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule